// File: doc/BRIEF.md
# Slave Stereo Serial Audio Port

This block sits between an external serial audio bus and the parallel sample paths of an audio codec core. It is a slave: the bit clock and the word select come from outside, and the block follows them. Playback samples arrive one bit at a time on a data input. The block assembles each left and right word into a 20-bit parallel sample and presents the pair with a one-cycle valid strobe. Record samples are taken in as 20-bit parallel words and shifted out on a data output in step with the same bit clock.

The three serial lines are brought into the system clock domain through a synchronizer. Bit clock edges are then detected there. Data and word select are sampled on the rising bit clock edge, and the data output moves after the falling edge. A 3-bit format code picks the layout on each direction. Input and output need not share a layout: in the combined modes the output is left-justified while the input is right-justified, with a word length of 16, 18 or 20 bits.

Top module: `audio_serial_port`

## Requirements
- R1: Format code `fmt_i`: 000 selects I2S on input and output. 100 selects MSB-justified on both. Codes 001/101 select LSB-justified 16-bit input, 010/110 select 18-bit, and 011/111 select 20-bit; all of these use MSB-justified output.
- R2: I2S input: the MSB is sampled on the second rising bit clock edge after a word select change, and the next 19 bits follow. Word select low carries the left channel.
- R3: MSB-justified input: the MSB is sampled on the first rising edge after the word select change, and the next 19 bits follow. Bits beyond the 20th in a half-frame are ignored.
- R4: LSB-justified input of length N: only the last N bits before the next word select change are kept, sign-extended to 20 bits. Earlier bits in the half-frame are ignored.
- R5: `rx_valid_o` pulses for one system clock once a right word completes, with `rx_left_o`/`rx_right_o` holding that frame's pair. The outputs stay unchanged between pulses. No pulse is issued for a pair whose left half-frame began before it was observed.
- R6: MSB-justified output: the MSB is driven in the bit slot that starts at the word select change, followed by the other 19 bits MSB first and then zeros.
- R7: I2S output: zero is driven in the slot that starts at the word select change, then the MSB in the next slot, then the other 19 bits, then zeros.
- R8: Both record words are captured from `tx_left_i`/`tx_right_i` when a left half-frame starts. Changes to these inputs later in that frame have no effect on that frame's output.
- R9: After reset, `sd_o` stays low until the first left half-frame starts.
- R10: While in reset and right after it, `rx_valid_o`, `rx_left_o`, `rx_right_o` and `sd_o` are zero.
- R11: Input lines are sampled only at rising bit clock edges. `sd_o` changes only right after a detected falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 3 | Layout code for input and output |
| sck_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External word select, changes on falling bit clock |
| sd_i | input | 1 | Serial playback data in |
| sd_o | output | 1 | Serial record data out |
| rx_left_o | output | 20 | Received left sample |
| rx_right_o | output | 20 | Received right sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |
| tx_left_i | input | 20 | Left record sample to send |
| tx_right_i | input | 20 | Right record sample to send |

## Verification
The bench runs every format code and fills the unused slots of each half-frame with ones. An LSB-justified receiver that kept too many bits would return a wrong upper part, and an MSB receiver that did not stop at 20 bits would shift the word. Patterns set exactly the bit that becomes the sign bit at 16 and 18 bits, so a wrong sign extension shows up as a wrong value. The I2S one-slot offset is checked in both directions: a design that skipped the offset would return every word shifted by one bit. The record inputs are changed in the middle of each frame, and the bench also watches the partial half-frame right after reset. These catch late capture and early output, as well as a spurious valid strobe.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {LAY_I2S, LAY_MSB, LAY_LSB} in_layout_e;

  function automatic in_layout_e in_layout(input logic [2:0] fmt);
    if (fmt == 3'b000) return LAY_I2S;
    if (fmt == 3'b100) return LAY_MSB;
    return LAY_LSB;
  endfunction

  function automatic int lsb_len(input logic [2:0] fmt);
    case (fmt[1:0])
      2'b01:   return 16;
      2'b10:   return 18;
      default: return 20;
    endcase
  endfunction

  function automatic logic out_i2s(input logic [2:0] fmt);
    return fmt == 3'b000;
  endfunction
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] stg [STAGES];
  logic       sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sck_q <= 1'b0;
    end else begin
      stg[0] <= {sck_i, ws_i, sd_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_q <= stg[STAGES-1][2];
    end
  end

  assign rise_o = stg[STAGES-1][2] & ~sck_q;
  assign fall_o = ~stg[STAGES-1][2] & sck_q;
  assign ws_o   = stg[STAGES-1][1];
  assign sd_o   = stg[STAGES-1][0];
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int SW       = 20,
  parameter int MAX_BITS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          ws_i,
  input  logic          sd_i,
  input  logic [2:0]    fmt_i,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o,
  output logic          valid_o
);
  import asp_pkg::*;
  localparam int CW = $clog2(MAX_BITS + 1);
  localparam int IW = $clog2(SW);
  localparam logic [CW-1:0] SW_C = CW'(SW);

  logic          ws_d1, ws_eff_q, ws_eff, bnd, started, left_ok;
  logic [CW-1:0] cnt;
  logic [SW-1:0] msb_sr, lsb_sr, left_q;
  logic [SW-1:0] word_msb, word_lsb, word;
  logic [IW-1:0] n_lsb, sgn_idx;
  in_layout_e    lay;

  assign lay    = in_layout(fmt_i);
  // I2S is MSB-justified with word select seen one bit late
  assign ws_eff = (lay == LAY_I2S) ? ws_d1 : ws_i;
  assign bnd    = ws_eff != ws_eff_q;
  assign n_lsb  = IW'(lsb_len(fmt_i));
  assign sgn_idx = n_lsb - 1'b1;

  always_comb begin
    word_msb = msb_sr;
    if (cnt < SW_C) word_msb = msb_sr << (SW_C - cnt);
    for (int i = 0; i < SW; i++)
      word_lsb[i] = (IW'(i) < n_lsb) ? lsb_sr[i] : lsb_sr[sgn_idx];
    word = (lay == LAY_LSB) ? word_lsb : word_msb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_d1    <= 1'b0;
      ws_eff_q <= 1'b0;
      cnt      <= '0;
      msb_sr   <= '0;
      lsb_sr   <= '0;
      left_q   <= '0;
      started  <= 1'b0;
      left_ok  <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        ws_d1    <= ws_i;
        ws_eff_q <= ws_eff;
        lsb_sr   <= {lsb_sr[SW-2:0], sd_i};
        if (bnd) begin
          msb_sr <= {{(SW-1){1'b0}}, sd_i};
          cnt    <= CW'(1);
          if (!ws_eff_q) begin
            left_q  <= word;
            left_ok <= started;
          end else if (left_ok) begin
            left_o  <= left_q;
            right_o <= word;
            valid_o <= 1'b1;
            left_ok <= 1'b0;
          end
          if (!ws_eff) started <= 1'b1;
        end else begin
          if (cnt < SW_C) msb_sr <= {msb_sr[SW-2:0], sd_i};
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int SW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          ws_i,
  input  logic [2:0]    fmt_i,
  input  logic [SW-1:0] tx_left_i,
  input  logic [SW-1:0] tx_right_i,
  output logic          sd_o
);
  import asp_pkg::*;

  logic          ws_q, armed, sd_q, arm_now;
  logic [SW-1:0] sr, right_q, load;

  assign arm_now = armed | ~ws_i;

  always_comb begin
    load = ws_i ? right_q : tx_left_i;
    if (!arm_now) load = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q    <= 1'b0;
      armed   <= 1'b0;
      sd_q    <= 1'b0;
      sr      <= '0;
      right_q <= '0;
    end else if (fall_i) begin
      ws_q <= ws_i;
      if (ws_i != ws_q) begin
        if (!ws_i) begin
          right_q <= tx_right_i;
          armed   <= 1'b1;
        end
        if (out_i2s(fmt_i)) begin
          sd_q <= 1'b0;
          sr   <= load;
        end else begin
          sd_q <= load[SW-1];
          sr   <= load << 1;
        end
      end else begin
        sd_q <= sr[SW-1];
        sr   <= sr << 1;
      end
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int SW          = 20,
  parameter int MAX_BITS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    fmt_i,
  input  logic          sck_i,
  input  logic          ws_i,
  input  logic          sd_i,
  output logic          sd_o,
  output logic [SW-1:0] rx_left_o,
  output logic [SW-1:0] rx_right_o,
  output logic          rx_valid_o,
  input  logic [SW-1:0] tx_left_i,
  input  logic [SW-1:0] tx_right_i
);
  logic ws_s, sd_s, sck_rise, sck_fall;

  asp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .ws_o(ws_s), .sd_o(sd_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  asp_rx #(.SW(SW), .MAX_BITS(MAX_BITS)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(sck_rise), .ws_i(ws_s),
    .sd_i(sd_s), .fmt_i(fmt_i), .left_o(rx_left_o), .right_o(rx_right_o),
    .valid_o(rx_valid_o)
  );

  asp_tx #(.SW(SW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(sck_fall), .ws_i(ws_s),
    .fmt_i(fmt_i), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
    .sd_o(sd_o)
  );
endmodule

// File: rtl/asp_chk.sv
module asp_chk #(
  parameter int SW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rise_i,
  input logic          fall_i,
  input logic          rx_valid_i,
  input logic [SW-1:0] rx_left_i,
  input logic [SW-1:0] rx_right_i,
  input logic          sd_i
);
  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  p_left_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |-> $stable(rx_left_i));

  p_right_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |-> $stable(rx_right_i));

  p_valid_after_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> $past(rise_i));

  p_sd_fall_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sd_i));
endmodule

bind audio_serial_port asp_chk #(.SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(sck_rise), .fall_i(sck_fall),
  .rx_valid_i(rx_valid_o), .rx_left_i(rx_left_o), .rx_right_i(rx_right_o),
  .sd_i(sd_o)
);

// File: tb/audio_serial_port_tb_top.sv
module audio_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = '0;
  logic        bclk = 1'b1, ws = 1'b1, sdi = 1'b0;
  logic        sd_o, rx_valid_o;
  logic [19:0] rx_left_o, rx_right_o, tx_left_i = '0, tx_right_i = '0;
  int          checks = 0, errors = 0, nlog = 0;
  bit          done = 1'b0;
  logic [19:0] log_l [8];
  logic [19:0] log_r [8];

  always #10 clk = ~clk;

  audio_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .sck_i(bclk), .ws_i(ws),
    .sd_i(sdi), .sd_o(sd_o), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
    .rx_valid_o(rx_valid_o), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i)
  );

  always @(negedge clk) if (rx_valid_o && nlog < 8) begin
    log_l[nlog] = rx_left_o;
    log_r[nlog] = rx_right_o;
    nlog = nlog + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nlen(int f);
    case (f % 4) 1: return 16; 2: return 18; default: return 20; endcase
  endfunction

  function automatic logic inbit(int f, logic [19:0] w, int j);
    if (f == 0) return (j >= 1 && j <= 20) ? w[20-j] : 1'b1;
    if (f == 4) return (j < 20) ? w[19-j] : 1'b1;
    return (j >= 32 - nlen(f)) ? w[31-j] : 1'b1;
  endfunction

  function automatic logic txbit(int f, logic [19:0] t, int j);
    if (f == 0) return (j >= 1 && j <= 20) ? t[20-j] : 1'b0;
    return (j < 20) ? t[19-j] : 1'b0;
  endfunction

  function automatic logic [19:0] exp_rx(int f, logic [19:0] w);
    logic [19:0] o;
    int n;
    if (f == 0 || f == 4) return w;
    n = nlen(f);
    for (int i = 0; i < 20; i++) o[i] = (i < n) ? w[i] : w[n-1];
    return o;
  endfunction

  function automatic logic [19:0] pat(int f, int k, int ch);
    case (k)
      0: return ch ? 20'h7FFFF : 20'h80000;
      1: return ch ? 20'h08000 : 20'h18000;
      2: return ch ? 20'h20000 : 20'h00000;
      default: return 20'((k * 32'h2F3A5) ^ (f * 32'h1357) ^ (ch * 32'h9E37));
    endcase
  endfunction

  task automatic slot(input logic w, input logic d, output logic q);
    @(negedge clk); bclk = 1'b0; ws = w; sdi = d;
    repeat (7) @(negedge clk);
    q = sd_o;
    @(negedge clk); bclk = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic frame(int f, logic [19:0] l, logic [19:0] r, logic [19:0] tl, logic [19:0] tr);
    logic [31:0] got, exp;
    logic [19:0] w, t;
    logic q;
    tx_left_i = tl; tx_right_i = tr;
    for (int h = 0; h < 2; h++) begin
      w = h ? r : l; t = h ? tr : tl;
      for (int j = 0; j < 32; j++) begin
        if (h == 0 && j == 4) begin tx_left_i = ~tl; tx_right_i = ~tr; end
        slot(h[0], inbit(f, w, j), q);
        got[31-j] = q; exp[31-j] = txbit(f, t, j);
      end
      // R6 / R7 layout, R8 capture at left start, R11 output after falling edge
      chk($sformatf("%s R8 R11 tx fmt%0d half%0d", (f == 0) ? "R7" : "R6", f, h), got, exp);
    end
  endtask

  initial begin
    logic q, acc;
    for (int f = 0; f < 8; f++) begin
      rst_n = 1'b0; fmt = 3'(f); bclk = 1'b1; ws = 1'b1; sdi = 1'b0;
      repeat (5) @(negedge clk);
      nlog = 0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 reset outputs", {rx_valid_o, sd_o, rx_left_o, rx_right_o}, '0);
      acc = 1'b0;
      for (int j = 0; j < 32; j++) begin slot(1'b1, 1'b1, q); acc |= q; end
      chk("R9 idle output low", {31'b0, acc}, 32'h0);
      for (int k = 0; k < 4; k++)
        frame(f, pat(f, k, 0), pat(f, k, 1), pat(f, k + 3, 0) ^ 20'hA5A5A, pat(f, k + 4, 1));
      frame(f, '0, '0, '0, '0);
      chk($sformatf("R5 valid count fmt%0d", f), nlog, 4);
      for (int k = 0; k < 4 && k < nlog; k++) begin
        chk($sformatf("R1 %s left fmt%0d frame%0d", (f == 0) ? "R2" : (f == 4) ? "R3" : "R4", f, k),
            {12'b0, log_l[k]}, {12'b0, exp_rx(f, pat(f, k, 0))});
        chk($sformatf("R1 %s R5 right fmt%0d frame%0d", (f == 0) ? "R2" : (f == 4) ? "R3" : "R4", f, k),
            {12'b0, log_r[k]}, {12'b0, exp_rx(f, pat(f, k, 1))});
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule